// File: doc/BRIEF.md
# Timer Event Capture Unit

This block records the value of a free-running 16-bit timer at the moment a chosen transition appears on an external event line. The event line is taken either from a device pin or from an analog comparator output; one control bit picks which. Both candidates are brought into the clock domain through a two-flop synchronizer. The selected level can then pass through an optional glitch filter before an edge detector whose polarity is programmable.

When the detector fires, the timer value is stored in a 16-bit capture register, a capture flag is raised and an interrupt request follows the flag. Software reads and writes the capture register over an 8-bit bus. A shared temporary byte keeps the two halves of a 16-bit access consistent. When the capture register is being used as the timer's period limit, the event path is shut off and no captures happen.

The timer counter, its prescaler, the waveform logic and the comparator itself sit outside this block. The timer value arrives as an input.

Top module: `capture_unit`

## Requirements
- R1: `src_cmp` = 0 selects `pin_evt` and `src_cmp` = 1 selects `cmp_evt`. Activity on the unselected line never causes a capture.
- R2: Toggling `src_cmp` while the two synchronized lines differ is treated as an edge on the selected level and causes a capture. That capture is not suppressed.
- R3: With the filter off, an input change driven before clock edge n loads the timer value present just before edge n+2 into the capture register.
- R4: With `filt_on` = 1, the filtered level follows the synchronized level only once four consecutive samples agree. A pulse lasting fewer than four cycles is ignored, and a held change loads the timer value present just before edge n+6 (four cycles later than R3).
- R5: `edge_rise` = 1 captures on a 0-to-1 transition and `edge_rise` = 0 on a 1-to-0 transition. The opposite transition has no effect.
- R6: While `cap_is_top` = 1, no capture occurs: the capture register and the flag are left unchanged.
- R7: A new capture overwrites an unread capture value. The flag simply stays set.
- R8: A bus write to address 1 stores the byte in the temporary latch. A write to address 0 commits {temporary latch, written byte} to the capture register.
- R9: A bus read at address 0 returns capture bits [7:0] and copies bits [15:8] into the temporary latch. A read at address 1 returns the temporary latch. Read data is combinational from `bus_addr`.
- R10: The flag (read at address 2, bit 0) sets on the edge that loads a capture, and `irq_req` equals it. Writing 1 to bit 0 at address 2 or pulsing `irq_ack` clears it. Writing 0 has no effect, and a capture in the same cycle as a clear wins.
- R11: After reset, the capture register, the temporary latch, the flag and `irq_req` are 0. Address 3 always reads 0.
- R12: When a capture and a low-byte write fall on the same edge, the capture value is stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pin_evt | input | 1 | Asynchronous event from the capture pin |
| cmp_evt | input | 1 | Asynchronous event from the comparator |
| src_cmp | input | 1 | Trigger source: 0 pin, 1 comparator |
| filt_on | input | 1 | Enable four-sample glitch filter |
| edge_rise | input | 1 | 1 rising edge, 0 falling edge |
| cap_is_top | input | 1 | Capture register serves as period limit; event path off |
| timer_val | input | 16 | Current timer count |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 2 | 0 low byte, 1 high byte, 2 flag, 3 unused |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data |
| irq_ack | input | 1 | Interrupt acknowledge pulse, clears the flag |
| irq_req | output | 1 | Interrupt request, equal to the capture flag |

## Verification
The event path is driven with single held steps of each polarity, and the captured value is compared against the timer count taken at the drive time. This pins down the synchronizer latency with and without the filter. Short pulses of one to three cycles with the filter on separate a four-sample filter from a shorter one. Transitions on the unselected source, transitions of the wrong polarity and transitions while the register serves as the period limit must all leave the register and flag untouched. A source switch between differing levels must capture. Bus sequences cover high-then-low writes, low-then-high reads, a write colliding with a capture, and flag clears by write and by acknowledge, including a clear that coincides with a capture.

// File: rtl/cap_pkg.sv
// Shared constants and the register address map for the capture unit.
package cap_pkg;
    localparam int BYTE_W = 8;

    typedef enum logic [1:0] {
        ADDR_LO   = 2'd0,
        ADDR_HI   = 2'd1,
        ADDR_FLAG = 2'd2,
        ADDR_NONE = 2'd3
    } cap_addr_e;
endpackage

// File: rtl/cap_cond.sv
// Input conditioning: synchronizes both event sources, selects one and
// optionally filters it. Assumes asynchronous inputs, SYNC_STAGES >= 2 and
// FILT_DEPTH >= 3. The filter adds exactly FILT_DEPTH cycles of latency.
module cap_cond #(
    parameter int SYNC_STAGES = 2,
    parameter int FILT_DEPTH  = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_evt,
    input  logic cmp_evt,
    input  logic src_cmp,
    input  logic filt_on,
    output logic level
);
    localparam int NSRC = 2;
    localparam int HW   = FILT_DEPTH - 1;

    logic [NSRC-1:0] raw;
    logic [NSRC-1:0] synced;
    logic            sel;
    logic [HW-1:0]   hist_q;
    logic            filt_q;
    logic            agree;

    assign raw = {cmp_evt, pin_evt};

    // One synchronizer chain per event source.
    for (genvar g = 0; g < NSRC; g++) begin : g_sync
        logic [SYNC_STAGES-1:0] chain_q;
        // Shift the raw level through the synchronizer flops.
        always_ff @(posedge clk) begin
            if (!rst_n) chain_q <= '0;
            else        chain_q <= {chain_q[SYNC_STAGES-2:0], raw[g]};
        end
        assign synced[g] = chain_q[SYNC_STAGES-1];
    end

    assign sel   = src_cmp ? synced[1] : synced[0];
    assign agree = (&{hist_q, sel}) | ~(|{hist_q, sel});

    // Keep the last HW samples of the selected level.
    always_ff @(posedge clk) begin
        if (!rst_n) hist_q <= '0;
        else        hist_q <= {hist_q[HW-2:0], sel};
    end

    // Filtered level moves only when all FILT_DEPTH samples agree.
    always_ff @(posedge clk) begin
        if (!rst_n)     filt_q <= 1'b0;
        else if (agree) filt_q <= sel;
    end

    assign level = filt_on ? filt_q : sel;
endmodule

// File: rtl/cap_edge.sv
// Edge detector: compares the conditioned level with its value one cycle
// earlier and reports the programmed transition. The previous level keeps
// tracking while gated, so ungating never produces a stale edge.
module cap_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic level,
    input  logic edge_rise,
    input  logic gate_off,
    output logic cap_evt
);
    logic prev_q;
    logic rise;
    logic fall;

    // Remember the level from the previous cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= level;
    end

    assign rise    = level & ~prev_q;
    assign fall    = ~level & prev_q;
    assign cap_evt = ~gate_off & (edge_rise ? rise : fall);
endmodule

// File: rtl/cap_regs.sv
// Capture register, temporary byte latch and capture flag behind an 8-bit
// bus. Assumes single-cycle strobes. A capture takes priority over a low
// byte write and over a flag clear. A high byte write takes priority over
// the read-side latch update.
module cap_regs
    import cap_pkg::*;
#(
    parameter int BW = BYTE_W,
    localparam int TW = 2 * BW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cap_evt,
    input  logic [TW-1:0] timer_val,
    input  logic          bus_wr,
    input  logic          bus_rd,
    input  logic [1:0]    bus_addr,
    input  logic [BW-1:0] bus_wdata,
    output logic [BW-1:0] bus_rdata,
    input  logic          irq_ack,
    output logic          flag,
    output logic [TW-1:0] cap_val,
    output logic [BW-1:0] tmp_val
);
    logic [TW-1:0] cap_q;
    logic [BW-1:0] tmp_q;
    logic          flag_q;
    logic          wr_lo;
    logic          wr_hi;
    logic          wr_clr;
    logic          rd_lo;

    assign wr_lo  = bus_wr && (bus_addr == ADDR_LO);
    assign wr_hi  = bus_wr && (bus_addr == ADDR_HI);
    assign wr_clr = bus_wr && (bus_addr == ADDR_FLAG) && bus_wdata[0];
    assign rd_lo  = bus_rd && (bus_addr == ADDR_LO);

    // Capture register: hardware capture first, then software commit.
    always_ff @(posedge clk) begin
        if (!rst_n)       cap_q <= '0;
        else if (cap_evt) cap_q <= timer_val;
        else if (wr_lo)   cap_q <= {tmp_q, bus_wdata};
    end

    // Temporary byte shared by 16-bit writes and reads.
    always_ff @(posedge clk) begin
        if (!rst_n)     tmp_q <= '0;
        else if (wr_hi) tmp_q <= bus_wdata;
        else if (rd_lo) tmp_q <= cap_q[TW-1:BW];
    end

    // Capture flag: set wins over either clear source.
    always_ff @(posedge clk) begin
        if (!rst_n)                  flag_q <= 1'b0;
        else if (cap_evt)            flag_q <= 1'b1;
        else if (irq_ack || wr_clr)  flag_q <= 1'b0;
    end

    // Combinational read mux.
    always_comb begin
        unique case (bus_addr)
            ADDR_LO:   bus_rdata = cap_q[BW-1:0];
            ADDR_HI:   bus_rdata = tmp_q;
            ADDR_FLAG: bus_rdata = {{(BW-1){1'b0}}, flag_q};
            default:   bus_rdata = '0;
        endcase
    end

    assign flag    = flag_q;
    assign cap_val = cap_q;
    assign tmp_val = tmp_q;
endmodule

// File: rtl/capture_unit.sv
// Top of the timer event capture unit. It chains input conditioning, edge
// detection and the register file. Assumes timer_val is synchronous to clk.
module capture_unit
    import cap_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int FILT_DEPTH  = 4
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        pin_evt,
    input  logic        cmp_evt,
    input  logic        src_cmp,
    input  logic        filt_on,
    input  logic        edge_rise,
    input  logic        cap_is_top,
    input  logic [15:0] timer_val,
    input  logic        bus_wr,
    input  logic        bus_rd,
    input  logic [1:0]  bus_addr,
    input  logic [7:0]  bus_wdata,
    output logic [7:0]  bus_rdata,
    input  logic        irq_ack,
    output logic        irq_req
);
    logic        level;
    logic        cap_evt;
    logic [15:0] cap_val;
    logic [7:0]  tmp_val;

    cap_cond #(.SYNC_STAGES(SYNC_STAGES), .FILT_DEPTH(FILT_DEPTH)) u_cond (
        .clk(clk), .rst_n(rst_n), .pin_evt(pin_evt), .cmp_evt(cmp_evt),
        .src_cmp(src_cmp), .filt_on(filt_on), .level(level)
    );

    cap_edge u_edge (
        .clk(clk), .rst_n(rst_n), .level(level), .edge_rise(edge_rise),
        .gate_off(cap_is_top), .cap_evt(cap_evt)
    );

    cap_regs #(.BW(BYTE_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .cap_evt(cap_evt), .timer_val(timer_val),
        .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_ack(irq_ack),
        .flag(irq_req), .cap_val(cap_val), .tmp_val(tmp_val)
    );
endmodule

// File: rtl/capture_unit_chk.sv
// Protocol checker for capture_unit, bound into every instance.
module capture_unit_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        cap_evt,
    input logic [15:0] timer_val,
    input logic [15:0] cap_val,
    input logic [7:0]  tmp_val,
    input logic        irq_req,
    input logic        irq_ack,
    input logic        bus_wr,
    input logic        bus_rd,
    input logic [1:0]  bus_addr,
    input logic [7:0]  bus_wdata,
    input logic        cap_is_top
);
    assert_flag_set_R10: assert property (@(posedge clk) disable iff (!rst_n)
        cap_evt |=> irq_req);

    assert_ack_clears_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_ack && !cap_evt) |=> !irq_req);

    assert_capture_value_R12: assert property (@(posedge clk) disable iff (!rst_n)
        cap_evt |=> (cap_val == $past(timer_val)));

    assert_gated_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (cap_is_top && !(bus_wr && bus_addr == 2'd0)) |=> $stable(cap_val));

    assert_hi_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == 2'd1) |=> (tmp_val == $past(bus_wdata)));

    assert_lo_commit_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == 2'd0 && !cap_evt)
        |=> (cap_val == {$past(tmp_val), $past(bus_wdata)}));

    assert_lo_read_latch_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr == 2'd0 && !(bus_wr && bus_addr == 2'd1))
        |=> (tmp_val == $past(cap_val[15:8])));
endmodule

bind capture_unit capture_unit_chk u_chk (
    .clk(clk), .rst_n(rst_n), .cap_evt(cap_evt), .timer_val(timer_val),
    .cap_val(cap_val), .tmp_val(tmp_val), .irq_req(irq_req),
    .irq_ack(irq_ack), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .cap_is_top(cap_is_top)
);

// File: tb/capture_unit_bench.sv
// Bench: behavioural reference model compared at every falling edge, plus
// directed checks against timer counts taken at drive time.
module capture_unit_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        pin_evt = 0, cmp_evt = 0, src_cmp = 0, filt_on = 0;
    logic        edge_rise = 1, cap_is_top = 0;
    logic [15:0] timer_val = 16'h12F0;
    logic        bus_wr = 0, bus_rd = 0, irq_ack = 0;
    logic [1:0]  bus_addr = 0;
    logic [7:0]  bus_wdata = 0;
    logic [7:0]  bus_rdata;
    logic        irq_req;

    int    checks = 0;
    int    failures = 0;
    string cur_req = "R11";
    bit    done = 0;

    always #4 clk = ~clk;

    capture_unit u_capture_unit (
        .clk(clk), .rst_n(rst_n), .pin_evt(pin_evt), .cmp_evt(cmp_evt),
        .src_cmp(src_cmp), .filt_on(filt_on), .edge_rise(edge_rise),
        .cap_is_top(cap_is_top), .timer_val(timer_val), .bus_wr(bus_wr),
        .bus_rd(bus_rd), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .irq_ack(irq_ack), .irq_req(irq_req)
    );

    // Reference model state
    bit     mp1, mp2, mc1, mc2, mfilt, mprev, mflag;
    bit     shist[$];
    int     mcap, mtmp;

    always @(posedge clk) begin
        if (!rst_n) begin
            {mp1, mp2, mc1, mc2, mfilt, mprev, mflag} = '0;
            shist = '{0, 0, 0};
            mcap = 0; mtmp = 0;
        end else begin
            bit sel, lvl, evt, agree;
            int ocap, otmp;
            sel   = src_cmp ? mc2 : mp2;
            lvl   = filt_on ? mfilt : sel;
            evt   = !cap_is_top && (edge_rise ? (lvl && !mprev) : (!lvl && mprev));
            agree = (shist[0] == sel) && (shist[1] == sel) && (shist[2] == sel);
            ocap = mcap; otmp = mtmp;
            if (agree) mfilt = sel;
            mprev = lvl;
            shist.push_front(sel);
            void'(shist.pop_back());
            mp2 = mp1; mp1 = pin_evt; mc2 = mc1; mc1 = cmp_evt;
            if (bus_wr && bus_addr == 1) mtmp = bus_wdata;
            else if (bus_rd && bus_addr == 0) mtmp = (ocap >> 8) & 255;
            if (evt) mcap = timer_val;
            else if (bus_wr && bus_addr == 0) mcap = (otmp << 8) | bus_wdata;
            if (evt) mflag = 1;
            else if (irq_ack || (bus_wr && bus_addr == 2 && bus_wdata[0])) mflag = 0;
        end
    end

    task automatic chk(input int act, input int exp, input string req, input string what);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Per-cycle comparison against the model.
    always @(negedge clk) begin
        if (rst_n && !done) begin
            int er;
            er = (bus_addr == 0) ? (mcap & 255) : (bus_addr == 1) ? mtmp :
                 (bus_addr == 2) ? int'(mflag) : 0;
            chk(bus_rdata, er, cur_req, "model rdata");
            chk(irq_req, mflag, cur_req, "model irq_req");
        end
    end

    task automatic tick();
        @(posedge clk); #2;
        timer_val = timer_val + 16'd1;
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) tick();
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        bus_wr = 1; bus_addr = a; bus_wdata = d;
        tick();
        bus_wr = 0; bus_addr = 0;
    endtask

    task automatic rd16(output int v);
        int lo, hi;
        bus_rd = 1; bus_addr = 0; #1 lo = bus_rdata;
        tick();
        bus_addr = 1; #1 hi = bus_rdata;
        tick();
        bus_rd = 0; bus_addr = 0;
        v = (hi << 8) | lo;
    endtask

    task automatic clear_flag();
        wr(2'd2, 8'h01);
    endtask

    initial begin
        #(8 * 200000);
        failures++;
        $display("FAIL watchdog expired");
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        int v, c0, prev;
        ticks(3);
        rst_n = 1;
        ticks(1);
        // R11 reset state
        cur_req = "R11";
        rd16(v); chk(v, 0, "R11", "capture after reset");
        bus_addr = 2; #1 chk(bus_rdata, 0, "R11", "flag after reset");
        bus_addr = 3; #1 chk(bus_rdata, 0, "R11", "addr3 reads 0");
        bus_addr = 0; ticks(2);

        // R3 / R5 rising capture, unfiltered
        cur_req = "R3"; c0 = timer_val; pin_evt = 1;
        ticks(5);
        chk(irq_req, 1, "R10", "flag set after capture");
        rd16(v); chk(v, c0 + 2, "R3", "unfiltered latency");
        clear_flag(); #1 chk(irq_req, 0, "R10", "write-1 clears flag");

        // R5 wrong polarity ignored, then falling mode
        cur_req = "R5"; prev = v; pin_evt = 0; ticks(5);
        chk(irq_req, 0, "R5", "falling ignored in rising mode");
        rd16(v); chk(v, prev, "R5", "register kept");
        edge_rise = 0; pin_evt = 1; ticks(5);
        chk(irq_req, 0, "R5", "rising ignored in falling mode");
        c0 = timer_val; pin_evt = 0; ticks(5);
        rd16(v); chk(v, c0 + 2, "R5", "falling capture value");
        clear_flag();

        // R1 unselected source ignored
        cur_req = "R1"; edge_rise = 1;
        cmp_evt = 1; ticks(4); cmp_evt = 0; ticks(4);
        chk(irq_req, 0, "R1", "comparator ignored when pin selected");
        src_cmp = 1; ticks(3);
        c0 = timer_val; cmp_evt = 1; ticks(5);
        rd16(v); chk(v, c0 + 2, "R1", "comparator capture");
        clear_flag(); pin_evt = 1; ticks(4); pin_evt = 0; ticks(4);
        chk(irq_req, 0, "R1", "pin ignored when comparator selected");

        // R2 source switch between differing levels
        cur_req = "R2"; cmp_evt = 0; ticks(4); src_cmp = 0; ticks(2);
        clear_flag(); cmp_evt = 1; ticks(4);
        c0 = timer_val; src_cmp = 1; ticks(3);
        chk(irq_req, 1, "R2", "switch causes capture");
        rd16(v); chk(v, c0, "R2", "switch capture value");
        clear_flag(); cmp_evt = 0; ticks(4); clear_flag();

        // R4 filter: short pulses rejected, held change delayed
        cur_req = "R4"; src_cmp = 0; ticks(2); filt_on = 1; ticks(6); clear_flag();
        for (int w = 1; w <= 3; w++) begin
            pin_evt = 1; ticks(w); pin_evt = 0; ticks(8);
            chk(irq_req, 0, "R4", $sformatf("pulse of %0d rejected", w));
        end
        c0 = timer_val; pin_evt = 1; ticks(5);
        chk(irq_req, 0, "R4", "not yet captured at n+5");
        ticks(3);
        rd16(v); chk(v, c0 + 6, "R4", "filtered latency");
        clear_flag(); pin_evt = 0; ticks(8); filt_on = 0; ticks(2);

        // R6 gated when capture register is period limit
        cur_req = "R6"; cap_is_top = 1; rd16(prev);
        pin_evt = 1; ticks(5); pin_evt = 0; ticks(5);
        chk(irq_req, 0, "R6", "no flag while gated");
        rd16(v); chk(v, prev, "R6", "register held while gated");
        cap_is_top = 0; ticks(2);

        // R7 overwrite without reading
        cur_req = "R7"; pin_evt = 1; ticks(4); pin_evt = 0; ticks(3);
        c0 = timer_val; pin_evt = 1; ticks(5);
        chk(irq_req, 1, "R7", "flag stays set");
        rd16(v); chk(v, c0 + 2, "R7", "second capture overwrites");
        clear_flag(); pin_evt = 0; ticks(3);

        // R8 / R9 16-bit write and read
        cur_req = "R8"; wr(2'd1, 8'hAB); wr(2'd0, 8'hCD);
        cur_req = "R9"; rd16(v); chk(v, 16'hABCD, "R8", "16-bit write");
        chk(irq_req, 0, "R8", "register write does not set flag");

        // R12 capture beats low byte write
        cur_req = "R12"; wr(2'd1, 8'h55);
        c0 = timer_val; pin_evt = 1; ticks(2);
        wr(2'd0, 8'h66); ticks(2);
        rd16(v); chk(v, c0 + 2, "R12", "capture wins over write");

        // R10 ack clear, write-0 no effect, set wins
        cur_req = "R10"; wr(2'd2, 8'h00);
        chk(irq_req, 1, "R10", "write 0 no effect");
        irq_ack = 1; tick(); irq_ack = 0; #1
        chk(irq_req, 0, "R10", "ack clears");
        pin_evt = 0; ticks(3);
        pin_evt = 1; ticks(2); irq_ack = 1; tick(); irq_ack = 0; #1
        chk(irq_req, 1, "R10", "capture wins over ack");
        ticks(3);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule